// File: doc/BRIEF.md
# Multi-rate TDM serial stream receiver

This block recovers 8-bit channel bytes from one serial time-division-multiplexed input line. The line carries its own bit clock, which runs at twice the highest stream rate in use, and a frame pulse. A two-bit rate code sets the stream rate to one of four values: 2.048, 4.096, 8.192 or 16.384 Mbps. The matching frame lengths are 32, 64, 128 and 256 channels. All four rates are counted from the same line clock. At the top rate one bit lasts two line-clock periods. Each halving of the rate doubles that length, up to 16 periods at the lowest rate.

The block runs on a faster system clock. The line clock, frame pulse and serial data are synchronous inputs that the block samples. A control input chooses whether rising or falling line-clock edges are the active edges. Only active edges time the stream and sample the frame pulse. Each received byte leaves the block as a one-cycle strobe together with the byte and its channel number. In a larger switch one receiver is instantiated per input line, and each receiver has its own rate code.

Top module: `tdm_stream_rx`

## Requirements
- R1: Rate code 0, 1, 2 and 3 give 16, 8, 4 and 2 line-clock periods per bit and 32, 64, 128 and 256 channels per frame.
- R2: With `edge_rise` = 1 only rising line-clock edges are active, and with 0 only falling ones. A low `frame_n` seen only at an inactive edge has no effect.
- R3: A low `frame_n` at an active edge marks a frame boundary. The line-clock period that this edge begins is the first period of bit 0 of channel 0, and every boundary restarts the bit and channel count, even mid-frame.
- R4: Each channel has 8 bits, sent most significant bit first, and `rx_byte` holds them with the first-received bit in bit 7.
- R5: Counting the periods of a bit from 0, with N periods per bit, the data is sampled at the active edge that begins period floor(3N/4): period 1, 3, 6 or 12 for rates 3, 2, 1 and 0.
- R6: After the sample of a channel's eighth bit, `rx_valid` is high for exactly one system clock, together with that byte and its channel index on `rx_chan`.
- R7: A change of `rate_sel` takes effect only at the next frame boundary.
- R8: After reset, no byte is delivered until the first frame boundary.
- R9: Without a new frame pulse, the channel count wraps from the last channel of the frame back to channel 0.
- R10: While `rst` is high, `rx_valid`, `rx_byte` and `rx_chan` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| line_ck | input | 1 | Line bit clock, sampled by `clk` |
| frame_n | input | 1 | Frame pulse, active low |
| edge_rise | input | 1 | 1: rising line edges are active; 0: falling |
| rate_sel | input | 2 | Stream rate code (0 = lowest rate, 3 = highest) |
| sdata | input | 1 | Serial data line |
| rx_byte | output | 8 | Received channel byte |
| rx_chan | output | 8 | Channel index of `rx_byte` |
| rx_valid | output | 1 | One-cycle strobe marking a delivered byte |

## Verification
An active line edge takes effect in the system clock in which its new level is first seen. The delivered byte, its channel and the strobe appear one clock after the edge that samples the eighth bit. The bench changes every input on the falling system-clock edge. At the next falling edge it first compares the outputs, which are then due from the inputs it drove one clock earlier, and only then drives again. For every active edge it drives, the bench's own model of the frame computes whether a byte must appear on the following compare, and which byte and channel it must carry. The bench checks the strobe on every compare, so a strobe that comes early, comes late or should not come at all is reported.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  localparam int RATE_W    = 2;
  localparam int NUM_RATES = 4;
  typedef logic [RATE_W-1:0] rate_t;
endpackage

// File: rtl/tdm_rx_edge.sv
module tdm_rx_edge (
  input  logic clk,
  input  logic rst,
  input  logic line_ck,
  input  logic frame_n,
  input  logic edge_rise,
  output logic act,
  output logic bound
);
  logic ck_q;

  always_ff @(posedge clk) begin
    if (rst) ck_q <= 1'b0;
    else     ck_q <= line_ck;
  end

  always_comb begin
    act   = edge_rise ? (line_ck & ~ck_q) : (~line_ck & ck_q);
    bound = act & ~frame_n;
  end
endmodule

// File: rtl/tdm_rx_timer.sv
module tdm_rx_timer
  import tdm_rx_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int TOP_TICKS  = 2,
  parameter int BASE_CHANS = 32,
  parameter int CHAN_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act,
  input  logic              bound,
  input  rate_t             rate_sel,
  output logic              locked,
  output logic              samp,
  output logic              samp_last,
  output logic [CHAN_W-1:0] samp_chan
);
  localparam int MAX_TICKS = TOP_TICKS << (NUM_RATES - 1);
  localparam int TICK_W    = $clog2(MAX_TICKS);
  localparam int BIT_W     = $clog2(BYTE_W);

  rate_t             rate_q;
  logic [TICK_W-1:0] tick;
  logic [BIT_W-1:0]  bitc;
  logic [CHAN_W-1:0] chan;

  logic [TICK_W:0]   n_ticks;
  logic [CHAN_W:0]   n_ch;
  logic [TICK_W+2:0] three_n;
  logic [TICK_W:0]   samp_k;
  logic [TICK_W:0]   tick_nx;
  logic [CHAN_W:0]   chan_nx;

  always_comb begin
    n_ticks   = (TICK_W+1)'(MAX_TICKS) >> rate_q;
    n_ch      = (CHAN_W+1)'(BASE_CHANS) << rate_q;
    three_n   = {2'b00, n_ticks} + {1'b0, n_ticks, 1'b0};
    samp_k    = three_n[TICK_W+2:2];
    tick_nx   = {1'b0, tick} + 1'b1;
    chan_nx   = {1'b0, chan} + 1'b1;
    samp_last = (bitc == BIT_W'(BYTE_W - 1));
    samp      = act & ~bound & locked & (tick_nx == samp_k);
    samp_chan = chan;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
      rate_q <= '0;
      tick   <= '0;
      bitc   <= '0;
      chan   <= '0;
    end else if (bound) begin
      locked <= 1'b1;
      rate_q <= rate_sel;
      tick   <= '0;
      bitc   <= '0;
      chan   <= '0;
    end else if (act && locked) begin
      if (tick_nx == n_ticks) begin
        tick <= '0;
        if (samp_last) begin
          bitc <= '0;
          chan <= (chan_nx == n_ch) ? '0 : chan_nx[CHAN_W-1:0];
        end else begin
          bitc <= bitc + 1'b1;
        end
      end else begin
        tick <= tick_nx[TICK_W-1:0];
      end
    end
  end

  p_stall_r2: assert property (@(posedge clk) disable iff (rst)
    !act |=> ($stable(tick) && $stable(bitc) && $stable(chan) && $stable(locked)));

  p_resync_r3: assert property (@(posedge clk) disable iff (rst)
    bound |=> (tick == '0 && bitc == '0 && chan == '0 && locked));

  p_rate_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !bound |=> $stable(rate_q));

  p_range_r1: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, tick} < n_ticks) && ({1'b0, chan} < n_ch));
endmodule

// File: rtl/tdm_rx_assemble.sv
module tdm_rx_assemble #(
  parameter int BYTE_W = 8,
  parameter int CHAN_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              samp,
  input  logic              samp_last,
  input  logic [CHAN_W-1:0] samp_chan,
  input  logic              sdata,
  output logic [BYTE_W-1:0] rx_byte,
  output logic [CHAN_W-1:0] rx_chan,
  output logic              rx_valid
);
  logic [BYTE_W-2:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr       <= '0;
      rx_byte  <= '0;
      rx_chan  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (samp) begin
        sr <= {sr[BYTE_W-3:0], sdata};
        if (samp_last) begin
          rx_byte  <= {sr, sdata};
          rx_chan  <= samp_chan;
          rx_valid <= 1'b1;
        end
      end
    end
  end

  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
endmodule

// File: rtl/tdm_stream_rx.sv
module tdm_stream_rx
  import tdm_rx_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int TOP_TICKS  = 2,
  parameter int BASE_CHANS = 32,
  parameter int CHAN_W     = $clog2(BASE_CHANS << (NUM_RATES - 1))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_ck,
  input  logic              frame_n,
  input  logic              edge_rise,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              sdata,
  output logic [BYTE_W-1:0] rx_byte,
  output logic [CHAN_W-1:0] rx_chan,
  output logic              rx_valid
);
  logic              act_w;
  logic              bound_w;
  logic              lock_w;
  logic              samp_w;
  logic              last_w;
  logic [CHAN_W-1:0] chan_w;

  tdm_rx_edge edge_i (
    .clk(clk), .rst(rst), .line_ck(line_ck), .frame_n(frame_n),
    .edge_rise(edge_rise), .act(act_w), .bound(bound_w)
  );

  tdm_rx_timer #(
    .BYTE_W(BYTE_W), .TOP_TICKS(TOP_TICKS), .BASE_CHANS(BASE_CHANS), .CHAN_W(CHAN_W)
  ) timer_i (
    .clk(clk), .rst(rst), .act(act_w), .bound(bound_w), .rate_sel(rate_sel),
    .locked(lock_w), .samp(samp_w), .samp_last(last_w), .samp_chan(chan_w)
  );

  tdm_rx_assemble #(.BYTE_W(BYTE_W), .CHAN_W(CHAN_W)) asm_i (
    .clk(clk), .rst(rst), .samp(samp_w), .samp_last(last_w), .samp_chan(chan_w),
    .sdata(sdata), .rx_byte(rx_byte), .rx_chan(rx_chan), .rx_valid(rx_valid)
  );

  p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !lock_w |-> !rx_valid);
endmodule

// File: tb/tdm_stream_rx_tb_top.sv
module tdm_stream_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line_ck = 1'b1;
  logic       frame_n = 1'b1;
  logic       edge_rise = 1'b0;
  logic [1:0] rate_sel = 2'd3;
  logic       sdata = 1'b0;
  logic [7:0] rx_byte;
  logic [7:0] rx_chan;
  logic       rx_valid;

  int nchk = 0;
  int nerr = 0;
  string tag = "R10";

  logic er = 1'b0;
  bit   locked = 0;
  int   eff = 0;
  int   iv = 0;
  int   fid = 0;
  bit   pv = 0;
  logic [7:0] pb = '0;
  int   pc = 0;
  logic idle_d = 1'b0;

  always #2.5 clk = ~clk;

  tdm_stream_rx dut_i (
    .clk(clk), .rst(rst), .line_ck(line_ck), .frame_n(frame_n),
    .edge_rise(edge_rise), .rate_sel(rate_sel), .sdata(sdata),
    .rx_byte(rx_byte), .rx_chan(rx_chan), .rx_valid(rx_valid)
  );

  function automatic logic [7:0] pat(input int c, input int f);
    return 8'(c * 29 + f * 71 + 3);
  endfunction

  task automatic check();
    nchk++;
    if (rx_valid !== pv) begin
      nerr++;
      $display("FAIL %s R6 valid: actual %b expected %b", tag, rx_valid, pv);
    end
    if (pv && rx_valid === 1'b1) begin
      nchk++;
      if (rx_byte !== pb || rx_chan !== 8'(pc)) begin
        nerr++;
        $display("FAIL %s R4 R5 byte/chan: actual %h/%0d expected %h/%0d",
                 tag, rx_byte, rx_chan, pb, pc);
      end
    end
    pv = 0;
  endtask

  task automatic lp(input bit fp, input bit glitch);
    int n, k, t, b, c;
    logic [7:0] v;
    logic d;
    @(negedge clk);
    check();
    if (fp) begin
      eff = int'(rate_sel); locked = 1; iv = 0; fid++;
    end else if (locked) begin
      iv++;
      if (iv == (32 << eff) * 8 * (16 >> eff)) iv = 0;
    end
    idle_d = ~idle_d;
    d = idle_d;
    if (locked) begin
      n = 16 >> eff; k = (3 * n) / 4;
      t = iv % n; b = (iv / n) % 8; c = iv / (8 * n);
      v = pat(c, fid);
      d = v[7-b];
      if (!fp && t == k && b == 7) begin pv = 1; pb = v; pc = c; end
    end
    line_ck = er; frame_n = ~fp; sdata = d;
    @(negedge clk);
    check();
    line_ck = ~er; frame_n = ~glitch;
  endtask

  task automatic do_reset(input logic e);
    rst = 1'b1; er = e; edge_rise = e; line_ck = ~e; frame_n = 1'b1; sdata = 1'b0;
    pv = 0; locked = 0; iv = 0;
    repeat (3) @(negedge clk);
    nchk++;
    if (rx_valid !== 1'b0 || rx_byte !== 8'h00 || rx_chan !== 8'h00) begin
      nerr++;
      $display("FAIL R10 reset outputs: actual %b/%h/%h expected 0/00/00",
               rx_valid, rx_byte, rx_chan);
    end
    rst = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    tag = "R10";
    do_reset(1'b0);
    // R8: clocks and data but no frame pulse yet
    tag = "R8"; rate_sel = 2'd3;
    repeat (40) lp(0, 0);
    // R1: full frame at each rate, falling-edge mode
    tag = "R1";
    for (int r = 0; r < 4; r++) begin
      rate_sel = 2'(r);
      lp(1, 0);
      repeat (4095) lp(0, 0);
    end
    // R9: run past the frame end with no pulse
    tag = "R9"; rate_sel = 2'd3;
    lp(1, 0);
    repeat (4395) lp(0, 0);
    // R7: rate code changed mid-frame
    tag = "R7"; rate_sel = 2'd3;
    lp(1, 0);
    repeat (2000) lp(0, 0);
    rate_sel = 2'd0;
    repeat (2095) lp(0, 0);
    lp(1, 0);
    repeat (1200) lp(0, 0);
    // R3: early frame pulse mid-channel
    tag = "R3"; rate_sel = 2'd2;
    lp(1, 0);
    repeat (333) lp(0, 0);
    lp(1, 0);
    repeat (900) lp(0, 0);
    // R2: rising-edge mode, frame pulse glitches at inactive edges
    do_reset(1'b1);
    tag = "R2"; rate_sel = 2'd2;
    lp(1, 0);
    for (int i = 0; i < 1500; i++) lp(0, (i % 97) == 50);
    rate_sel = 2'd3;
    lp(1, 0);
    repeat (600) lp(0, 0);
    @(negedge clk);
    check();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule